// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for every beat of a short burst to a synchronous memory. A burst begins when either of two independent address strobes is asserted. One strobe is meant for a processor and one for a cache controller. On that clock edge the full incoming address is captured as the burst's start. From then on the low-order address bits are generated internally. They step to the next beat only on clock edges where the advance input is high.

The burst is four beats long, since the beat counter has two bits by default. A run-time order input picks between two sequences. In the interleaved order, the start's low bits are XORed with the beat number. In the linear order, the beat number is added to the start's low bits, and the sum wraps inside the aligned group of four words. The upper address bits always stay at the captured start value. The memory array, write path and output drivers sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the held start address and the beat index, so `cur_addr` and `beat_idx` read zero.
- R2: At a rising edge where `strobe_cpu` or `strobe_ctl` is high, the whole of `addr_in` is captured. From that edge on, `cur_addr` equals the captured value and `beat_idx` is 0.
- R3: At a rising edge where `advance` is high and neither strobe is high, `beat_idx` increments by one, modulo 4.
- R4: Between captures, the bits of `cur_addr` above the two low bits stay equal to the captured start address.
- R5: With `order_ilv` = 1 (interleaved), `cur_addr[1:0]` equals the start's bits [1:0] XOR `beat_idx`.
- R6: With `order_ilv` = 0 (linear), `cur_addr[1:0]` equals the start's bits [1:0] plus `beat_idx`, modulo 4.
- R7: When a strobe and `advance` are both high at the same edge, the strobe wins. The new address is loaded and `beat_idx` becomes 0.
- R8: At an edge with no strobe and `advance` low, `cur_addr` and `beat_idx` keep their values.
- R9: A fourth advance after a capture returns `beat_idx` to 0 and `cur_addr` to the start address.
- R10: Changes on `addr_in` at edges without a strobe have no effect on `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | Incoming word address, sampled on a strobe |
| strobe_cpu | input | 1 | Processor-side address strobe, active high |
| strobe_ctl | input | 1 | Controller-side address strobe, active high |
| advance | input | 1 | Step to the next beat, active high |
| order_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| cur_addr | output | ADDR_W | Address of the current beat |
| beat_idx | output | BEAT_W | Beat number within the burst |

## Verification
Captures, advances and holds all take effect at the single rising edge where they are sampled. Their results are therefore due on `cur_addr` and `beat_idx` right after that edge, with zero cycles of added latency. The order input acts combinationally, so a change on it shows up on the low address bits within the same cycle. The bench drives each input on the falling edge. It waits for the next rising edge and reads the outputs one nanosecond later, so each check sees exactly one edge's worth of change.

// File: rtl/burst_pkg.sv
package burst_pkg;
   // encoding of the run-time order input
   typedef enum logic {
      ORDER_LINEAR     = 1'b0,
      ORDER_INTERLEAVE = 1'b1
   } burst_order_e;

   // smallest legal counter width
   localparam int unsigned MIN_BEAT_W = 1;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_d,
   output logic [ADDR_W-1:0] start_q
);
   generate
      if (ADDR_W < 2) begin : g_bad_w
         $error("burst_start_reg: ADDR_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       start_q <= '0;
      else if (load) start_q <= addr_d;
   end

   // R2
   capture_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> start_q == $past(addr_d));

   // R10
   no_capture_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(start_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              adv,
   output logic [BEAT_W-1:0] beat_q
);
   import burst_pkg::*;

   generate
      if (BEAT_W < MIN_BEAT_W) begin : g_bad_w
         $error("burst_beat_ctr: BEAT_W below minimum");
      end
   endgenerate

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk) begin
      if (rst)       beat_q <= '0;
      else if (load) beat_q <= '0;
      else if (adv)  beat_q <= beat_q + ONE;
   end

   // R3
   step_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && !load) |=> beat_q == $past(beat_q) + ONE);

   // R7
   load_wins_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> beat_q == '0);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!adv && !load) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] base_lo,
   input  logic [BEAT_W-1:0] beat,
   input  logic              interleave,
   output logic [BEAT_W-1:0] lo_out
);
   import burst_pkg::*;

   logic [BEAT_W-1:0] xor_lo;
   logic [BEAT_W-1:0] lin_lo;

   // per-bit XOR stage for the interleaved order
   genvar gi;
   generate
      for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
         assign xor_lo[gi] = base_lo[gi] ^ beat[gi];
      end
   endgenerate

   // wrapping add for the linear order (carry out dropped)
   assign lin_lo = base_lo + beat;

   always_comb begin
      if (burst_order_e'(interleave) == ORDER_INTERLEAVE) lo_out = xor_lo;
      else                                                lo_out = lin_lo;
   end

   logic [BEAT_W-1:0] undo_xor;
   logic [BEAT_W-1:0] undo_add;
   assign undo_xor = lo_out ^ base_lo;
   assign undo_add = lo_out - base_lo;

   always_comb begin
      if (!$isunknown({base_lo, beat, interleave})) begin
         // R5
         ilv_order_chk: assert (!interleave || undo_xor == beat);
         // R6
         lin_order_chk: assert (interleave || undo_add == beat);
      end
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              strobe_cpu,
   input  logic              strobe_ctl,
   input  logic              advance,
   input  logic              order_ilv,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [BEAT_W-1:0] beat_idx
);
   localparam int unsigned HI_W = ADDR_W - BEAT_W;

   generate
      if (ADDR_W <= BEAT_W) begin : g_bad_split
         $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic              load;
   logic [ADDR_W-1:0] start_q;
   logic [BEAT_W-1:0] lo_mapped;

   assign load = strobe_cpu | strobe_ctl;

   burst_start_reg #(.ADDR_W(ADDR_W)) i_start (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .addr_d (addr_in),
      .start_q(start_q)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) i_ctr (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .adv   (advance),
      .beat_q(beat_idx)
   );

   burst_order_map #(.BEAT_W(BEAT_W)) i_map (
      .base_lo   (start_q[BEAT_W-1:0]),
      .beat      (beat_idx),
      .interleave(order_ilv),
      .lo_out    (lo_mapped)
   );

   assign cur_addr = {start_q[ADDR_W-1:BEAT_W], lo_mapped};

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (cur_addr == '0 && beat_idx == '0));

   // R2
   strobe_addr_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> cur_addr == $past(addr_in));

   // R4
   upper_held_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

   // HI_W is part of the documented split; keep it referenced
   generate
      if (HI_W == 0) begin : g_no_hi
         $error("burst_addr_gen: no upper address bits");
      end
   endgenerate
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
   localparam int AW = 16;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic [AW-1:0] addr_in;
   logic          strobe_cpu, strobe_ctl, advance, order_ilv;
   logic [AW-1:0] cur_addr;
   logic [BW-1:0] beat_idx;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_gen (
      .clk(clk), .rst(rst), .addr_in(addr_in),
      .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
      .advance(advance), .order_ilv(order_ilv),
      .cur_addr(cur_addr), .beat_idx(beat_idx)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] model(input logic [AW-1:0] s, input logic [1:0] b, input logic ilv);
      logic [1:0] lo;
      lo = ilv ? (s[1:0] ^ b) : (s[1:0] + b);
      return {s[AW-1:2], lo};
   endfunction

   // drive on falling edge, then sample 1 ns after the next rising edge
   task automatic step(input logic sc, input logic sk, input logic adv, input logic [AW-1:0] a);
      @(negedge clk);
      strobe_cpu = sc; strobe_ctl = sk; advance = adv; addr_in = a;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); rst = 1'b0;
      check("R1 addr", cur_addr, '0);
      check("R1 beat", beat_idx, '0);
   endtask

   task automatic t_interleave;
      logic [AW-1:0] s = 16'hABC6;
      order_ilv = 1'b1;
      step(1, 0, 0, s);
      check("R2 cpu capture", cur_addr, s);
      check("R2 beat zero", beat_idx, 0);
      for (int b = 1; b < 4; b++) begin
         step(0, 0, 1, 16'h0000);
         check("R3 beat", beat_idx, b);
         check("R5 ilv addr", cur_addr, model(s, b[1:0], 1'b1));
         check("R4 upper", cur_addr[AW-1:2], s[AW-1:2]);
      end
      step(0, 0, 1, 16'h5555);
      check("R9 wrap beat", beat_idx, 0);
      check("R9 wrap addr", cur_addr, s);
   endtask

   task automatic t_linear;
      logic [AW-1:0] s = 16'h0F03;
      order_ilv = 1'b0;
      step(0, 1, 0, s);
      check("R2 ctl capture", cur_addr, s);
      for (int b = 1; b < 4; b++) begin
         step(0, 0, 1, 16'hFFFF);
         check("R6 lin addr", cur_addr, model(s, b[1:0], 1'b0));
      end
      order_ilv = 1'b1; #1;
      check("R5 mode flip", cur_addr, model(s, 2'd3, 1'b1));
      order_ilv = 1'b0;
   endtask

   task automatic t_hold;
      logic [AW-1:0] s = 16'h1235;
      order_ilv = 1'b0;
      step(1, 0, 0, s);
      step(0, 0, 1, 16'h0000);
      for (int i = 0; i < 3; i++) begin
         step(0, 0, 0, 16'h9A00 + AW'(i));
         check("R8 hold beat", beat_idx, 1);
         check("R10 addr ignored", cur_addr, model(s, 2'd1, 1'b0));
      end
   endtask

   task automatic t_priority;
      logic [AW-1:0] s = 16'h7772;
      order_ilv = 1'b1;
      step(1, 0, 0, 16'h4440);
      step(0, 0, 1, 16'h0);
      step(0, 0, 1, 16'h0);
      step(0, 1, 1, s);
      check("R7 strobe wins beat", beat_idx, 0);
      check("R7 strobe wins addr", cur_addr, s);
      step(1, 1, 1, 16'h2221);
      check("R7 both strobes", cur_addr, 16'h2221);
   endtask

   task automatic t_mid_reset;
      step(1, 0, 0, 16'hBEEF);
      step(0, 0, 1, 16'h0);
      t_reset();
   endtask

   initial begin
      rst = 1'b1; addr_in = '0; strobe_cpu = 0; strobe_ctl = 0;
      advance = 0; order_ilv = 0;
      repeat (2) @(posedge clk);
      t_reset();
      t_interleave();
      t_linear();
      t_hold();
      t_priority();
      t_mid_reset();
      step(0, 0, 0, 16'h0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule